// File: doc/BRIEF.md
# MMU Exception Capture Register File

This block holds the software-visible translation control state of a 32-bit processor: a page-entry-high register (virtual page number plus address-space identifier), a page-entry-low register, a table-base register, a fault-address register and a control register. Software reaches them with longword accesses on a simple request bus at fixed addresses at the top of the address map. Any access made outside privileged mode is refused and flagged.

When the core takes an MMU or address-error exception, the block loads the faulting virtual address into the fault-address register. In the same cycle it loads the upper 22 address bits into the page-number field of page-entry-high. A TLB-load command makes the block present the page number, the identifier and the page-entry-low contents to a TLB write port as one entry, in the same cycle.

Top module: `mmu_ctl_regs`

## Requirements
- R1: In privileged mode, a write updates only the register at its address. The addresses are: page-entry-high 0xFFFFFFF0, page-entry-low 0xFFFFFFF4, table-base 0xFFFFFFF8, fault-address 0xFFFFFFFC and control 0xFFFFFFE0. A read raises `bus_rvalid` in the next cycle with that register's value on `bus_rdata`.
- R2: A user-mode access to any of the five addresses (`bus_priv` low) changes no register. It pulses `bus_acc_err` in the next cycle, and a user-mode read returns zero.
- R3: Page-entry-high keeps the identifier in bits [7:0] and the page number in bits [31:10]. Bits [9:8] read as zero and ignore writes.
- R4: On `exc_valid`, the fault-address register takes the whole of `exc_vaddr`. The page-number field of page-entry-high takes `exc_vaddr[31:10]`. The identifier is kept unchanged.
- R5: An exception leaves page-entry-low, table-base and the control register unchanged.
- R6: If a software write to page-entry-high or to the fault-address register falls in the same cycle as `exc_valid`, the capture wins and the write is dropped.
- R7: While `tlb_load` is high, `tlb_wr_valid` is high in that same cycle. The port then carries the page number (`tlb_wr_vpn` = page-entry-high[31:10]), the identifier and the page-entry-low value as they stand in that cycle.
- R8: Reset clears every bit of the control register except the supervisor bit at position 8, which is left undefined. The other four registers are not reset.
- R9: A privileged access to any other address changes no register, reads as zero and raises no `bus_acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or manual) |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Longword address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Requester is in privileged mode |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| bus_acc_err | output | 1 | User-mode access was refused, one cycle after the request |
| exc_valid | input | 1 | MMU or address-error exception taken this cycle |
| exc_vaddr | input | 32 | Faulting virtual address |
| tlb_load | input | 1 | TLB-load command |
| tlb_wr_valid | output | 1 | TLB write port valid |
| tlb_wr_vpn | output | 22 | Page number for the TLB entry |
| tlb_wr_asid | output | ASID_W | Address-space identifier for the TLB entry |
| tlb_wr_pte | output | 32 | Page-entry-low contents for the TLB entry |

## Verification
The hardest case to reach is an exception capture that lands in the same cycle as a software write to page-entry-high. The bench drives it by raising `exc_valid` in the very request cycle of a privileged write. It then reads the register back and expects the captured page number alongside the identifier written earlier. A TLB-load issued right after the capture shows that the write port takes the captured value, not the dropped one.

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs #(
  parameter int ASID_W = 8,
  parameter int SV_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_priv,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              bus_acc_err,
  input  logic              exc_valid,
  input  logic [31:0]       exc_vaddr,
  input  logic              tlb_load,
  output logic              tlb_wr_valid,
  output logic [21:0]       tlb_wr_vpn,
  output logic [ASID_W-1:0] tlb_wr_asid,
  output logic [31:0]       tlb_wr_pte
);
  localparam logic [31:0] A_HI  = 32'hFFFF_FFF0;
  localparam logic [31:0] A_LO  = 32'hFFFF_FFF4;
  localparam logic [31:0] A_TB  = 32'hFFFF_FFF8;
  localparam logic [31:0] A_FA  = 32'hFFFF_FFFC;
  localparam logic [31:0] A_CR  = 32'hFFFF_FFE0;
  localparam logic [31:0] SV_MASK = 32'd1 << SV_BIT;

  logic [21:0]       vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [31:0]       lo_q, tb_q, fa_q, cr_q;
  logic [31:0]       hi_rd, rd_mux;

  wire hit_hi = bus_addr == A_HI;
  wire hit_lo = bus_addr == A_LO;
  wire hit_tb = bus_addr == A_TB;
  wire hit_fa = bus_addr == A_FA;
  wire hit_cr = bus_addr == A_CR;
  wire hit_any = hit_hi | hit_lo | hit_tb | hit_fa | hit_cr;
  wire wr_ok = bus_req & bus_wr & bus_priv;
  wire we_hi = wr_ok & hit_hi;
  wire we_lo = wr_ok & hit_lo;
  wire we_tb = wr_ok & hit_tb;
  wire we_fa = wr_ok & hit_fa;
  wire we_cr = wr_ok & hit_cr;

  always_ff @(posedge clk) begin
    if (exc_valid) begin
      vpn_q <= exc_vaddr[31:10];
      fa_q  <= exc_vaddr;
    end else begin
      if (we_hi) begin
        vpn_q  <= bus_wdata[31:10];
        asid_q <= bus_wdata[ASID_W-1:0];
      end
      if (we_fa) fa_q <= bus_wdata;
    end
    if (we_lo) lo_q <= bus_wdata;
    if (we_tb) tb_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cr_q <= cr_q & SV_MASK;
    else if (we_cr) cr_q <= bus_wdata;

  always_comb begin
    hi_rd = '0;
    hi_rd[31:10] = vpn_q;
    hi_rd[ASID_W-1:0] = asid_q;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_priv) begin
      if (hit_hi) rd_mux = hi_rd;
      if (hit_lo) rd_mux = lo_q;
      if (hit_tb) rd_mux = tb_q;
      if (hit_fa) rd_mux = fa_q;
      if (hit_cr) rd_mux = cr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rvalid  <= 1'b0;
      bus_rdata   <= '0;
      bus_acc_err <= 1'b0;
    end else begin
      bus_rvalid  <= bus_req & ~bus_wr;
      bus_rdata   <= (bus_req & ~bus_wr) ? rd_mux : '0;
      bus_acc_err <= bus_req & ~bus_priv & hit_any;
    end

  assign tlb_wr_valid = tlb_load;
  assign tlb_wr_vpn   = vpn_q;
  assign tlb_wr_asid  = asid_q;
  assign tlb_wr_pte   = lo_q;

  // R1
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_wr |=> bus_rvalid);
  // R2
  user_noupd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_priv |=> $stable(lo_q) && $stable(tb_q) && $stable(cr_q));
  // R2
  acc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_priv && hit_any |=> bus_acc_err);
  // R4
  exc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> fa_q == $past(exc_vaddr) && tlb_wr_vpn == $past(exc_vaddr[31:10]));
  // R5
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !bus_req |=> $stable(lo_q) && $stable(tb_q) && $stable(cr_q));
  // R6
  exc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> $stable(asid_q));
  // R8
  cr_rst_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (cr_q & ~SV_MASK) == 32'd0);
endmodule

// File: tb/tb_mmu_ctl_regs.sv
module tb_mmu_ctl_regs;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_wr = 0, bus_priv = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_rvalid, bus_acc_err;
  logic [31:0] bus_rdata;
  logic exc_valid = 0, tlb_load = 0;
  logic [31:0] exc_vaddr = 0;
  logic tlb_wr_valid;
  logic [21:0] tlb_wr_vpn;
  logic [7:0] tlb_wr_asid;
  logic [31:0] tlb_wr_pte;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$], mask_q[$];
  string tag_q[$];
  logic [31:0] vhi, vlo, vtb, vfa;

  always #5 clk = ~clk;

  mmu_ctl_regs dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (rst_n && bus_rvalid) begin
    if (exp_q.size() == 0) check("R1 unexpected rvalid", 32'd1, 32'd0);
    else begin
      logic [31:0] e, m;
      string t;
      e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
      check(t, bus_rdata & m, e & m);
    end
  end

  task automatic bus_access(bit wr, logic [31:0] a, logic [31:0] d, bit pr,
                            bit exc, logic [31:0] va, bit exp_err, string tag);
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_priv = pr;
    exc_valid = exc; exc_vaddr = va;
    @(negedge clk);
    bus_req = 0; exc_valid = 0;
    check({tag, " acc_err"}, {31'd0, bus_acc_err}, {31'd0, exp_err});
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, bit pr, bit err, string tag);
    bus_access(1, a, d, pr, 0, 0, err, tag);
  endtask

  task automatic rd(logic [31:0] a, bit pr, logic [31:0] e, logic [31:0] m, bit err, string tag);
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(tag);
    bus_access(0, a, 0, pr, 0, 0, err, tag);
  endtask

  task automatic exception(logic [31:0] va);
    @(negedge clk); exc_valid = 1; exc_vaddr = va;
    @(negedge clk); exc_valid = 0;
  endtask

  task automatic tlb_check(string tag);
    @(negedge clk); tlb_load = 1; #1;
    check({tag, " valid"}, {31'd0, tlb_wr_valid}, 32'd1);
    check({tag, " vpn"}, {10'd0, tlb_wr_vpn}, vhi >> 10);
    check({tag, " asid"}, {24'd0, tlb_wr_asid}, vhi & 32'hFF);
    check({tag, " pte"}, tlb_wr_pte, vlo);
    @(negedge clk); tlb_load = 0; #1;
    check({tag, " idle"}, {31'd0, tlb_wr_valid}, 32'd0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: control reads zero apart from the undefined supervisor bit 8
    rd(32'hFFFFFFE0, 1, 32'd0, ~32'h100, 0, "R8 control reset");
    // R3: bits 9:8 of page-entry-high drop
    wr(32'hFFFFFFF0, 32'hABCDE3FF, 1, 0, "R3 hi write");
    vhi = 32'hABCDE0FF;
    rd(32'hFFFFFFF0, 1, vhi, '1, 0, "R3 hi readback");
    // R1: each address
    vlo = 32'h12345678; vtb = 32'h0BADF00D; vfa = 32'h55AA55AA;
    wr(32'hFFFFFFF4, vlo, 1, 0, "R1 lo write");
    wr(32'hFFFFFFF8, vtb, 1, 0, "R1 tb write");
    wr(32'hFFFFFFFC, vfa, 1, 0, "R1 fa write");
    wr(32'hFFFFFFE0, 32'h0000A005, 1, 0, "R1 cr write");
    rd(32'hFFFFFFF4, 1, vlo, '1, 0, "R1 lo readback");
    rd(32'hFFFFFFF8, 1, vtb, '1, 0, "R1 tb readback");
    rd(32'hFFFFFFFC, 1, vfa, '1, 0, "R1 fa readback");
    rd(32'hFFFFFFE0, 1, 32'h0000A005, '1, 0, "R1 cr readback");
    // R9: unmapped address
    wr(32'hFFFFFFE4, 32'hDEADBEEF, 1, 0, "R9 unmapped write");
    rd(32'hFFFFFFE4, 1, 32'd0, '1, 0, "R9 unmapped read");
    rd(32'hFFFFFFF0, 1, vhi, '1, 0, "R9 hi intact");
    rd(32'hFFFFFFF4, 1, vlo, '1, 0, "R9 lo intact");
    // R2: user mode refused
    wr(32'hFFFFFFF4, 32'hFFFFFFFF, 0, 1, "R2 user write");
    wr(32'hFFFFFFF0, 32'h00000000, 0, 1, "R2 user hi write");
    rd(32'hFFFFFFF8, 0, 32'd0, '1, 1, "R2 user read");
    rd(32'hFFFFFFF4, 1, vlo, '1, 0, "R2 lo unchanged");
    rd(32'hFFFFFFF0, 1, vhi, '1, 0, "R2 hi unchanged");
    // R7
    tlb_check("R7 tlb load");
    // R4 / R5: exception capture
    exception(32'h76543ABC);
    vhi = (32'h76543ABC & 32'hFFFFFC00) | 32'hFF; vfa = 32'h76543ABC;
    rd(32'hFFFFFFF0, 1, vhi, '1, 0, "R4 hi capture");
    rd(32'hFFFFFFFC, 1, vfa, '1, 0, "R4 fa capture");
    rd(32'hFFFFFFF4, 1, vlo, '1, 0, "R5 lo after exception");
    rd(32'hFFFFFFF8, 1, vtb, '1, 0, "R5 tb after exception");
    rd(32'hFFFFFFE0, 1, 32'h0000A005, '1, 0, "R5 cr after exception");
    // R6: collision with a write
    bus_access(1, 32'hFFFFFFF0, 32'h99999933, 1, 1, 32'h11112222, 0, "R6 hi collision");
    vhi = 32'h111120FF; vfa = 32'h11112222;
    rd(32'hFFFFFFF0, 1, vhi, '1, 0, "R6 hi capture wins");
    bus_access(1, 32'hFFFFFFFC, 32'h0F0F0F0F, 1, 1, 32'h2468ACE0, 0, "R6 fa collision");
    vhi = (32'h2468ACE0 & 32'hFFFFFC00) | 32'hFF; vfa = 32'h2468ACE0;
    rd(32'hFFFFFFFC, 1, vfa, '1, 0, "R6 fa capture wins");
    tlb_check("R7 tlb after capture");
    repeat (3) @(negedge clk);
    check("R1 responses drained", exp_q.size(), 0);
    finish_run();
  end
endmodule